// File: doc/BRIEF.md
# Row-Buffered DRAM Array Model with Multiplexed Address

This block is a synthesizable behavioural model of a small dynamic memory. It holds ROWS x COLS cells of WIDTH bits each, arranged as a grid. A single narrow address bus is time-shared: a row strobe samples the bus as a row index, and a later column strobe samples the same bus as a column index. The row strobe copies the whole selected row into an internal row buffer and marks it open. Each column strobe is then served from that buffer, so repeated column accesses to an open row need no further row strobe.

A write is a column strobe with `we` high. It updates the buffered copy and the array cell together, so the open row never goes stale. A close request empties the buffer. A column strobe that arrives with no open row returns no data and instead pulses an error flag. The default geometry is 4 rows by 4 columns of 8-bit cells on a 2-bit address bus. Array cells clear to zero on reset.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset `rdata`, `rvalid` and `col_err` are 0, no row is open, and every array cell reads as 0.
- R2: A row strobe takes `addr` as the row index and opens that row. A later column read (column strobe, `we` low) takes `addr` as the column index. In the clock cycle after that column strobe, `rvalid` is 1 and `rdata` holds cell (row, column).
- R3: With a row open, column strobes in any number and any column order read cells of that same row until the next row strobe or close.
- R4: A column strobe with `we` high on an open row writes `wdata` into both the row buffer and the array cell. A later read of that column, either straight away or after closing and reopening the row, returns `wdata`. A write raises neither `rvalid` nor `col_err`.
- R5: A column strobe with no open row (after reset or after a close) sets `col_err` to 1, `rvalid` to 0 and `rdata` to 0 in the next cycle. If `we` is high, no cell changes.
- R6: `close_row` closes the open row, so column strobes fail until the next row strobe.
- R7: When strobes coincide in one cycle, the priority is `close_row` first, then `row_stb`, then `col_stb`. Only the highest active request acts, and the others are ignored.
- R8: `rvalid` and `col_err` are high for exactly one cycle per column strobe. In cycles without a column read and without an error, `rdata` keeps its last value.
- R9: A row strobe while a row is already open replaces the buffer contents with the newly addressed row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| close_row | input | 1 | Close the open row (highest priority) |
| row_stb | input | 1 | Row strobe: sample `addr` as row index and load the row buffer |
| col_stb | input | 1 | Column strobe: sample `addr` as column index and read or write |
| we | input | 1 | With `col_stb`: 1 writes `wdata`, 0 reads |
| addr | input | ADDR_W (2) | Shared row/column index |
| wdata | input | WIDTH (8) | Write data |
| rdata | output | WIDTH (8) | Read data, registered |
| rvalid | output | 1 | One-cycle pulse: `rdata` carries a fresh read |
| col_err | output | 1 | One-cycle pulse: column strobe with no open row |

## Verification
The checker assumes that strobes are sampled only on rising edges. It rebuilds the open/closed state purely from the port-level strobes and the priority rule, so its properties hold for any mix of simultaneous strobes. The bench drives every input on falling edges and holds each strobe for a single cycle. It exercises coinciding strobes on purpose, so the priority cases fall within what the checker assumes.

// File: rtl/mdram_pkg.sv
package mdram_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_CLOSE = 2'd1,
      CMD_OPEN  = 2'd2,
      CMD_COL   = 2'd3
   } mdram_cmd_e;

endpackage

// File: rtl/mdram_cmd_dec.sv
module mdram_cmd_dec
   import mdram_pkg::*;
(
   input  logic       close_row,
   input  logic       row_stb,
   input  logic       col_stb,
   output mdram_cmd_e cmd
);

   // fixed priority: close, then open, then column access
   always_comb begin
      if (close_row)    cmd = CMD_CLOSE;
      else if (row_stb) cmd = CMD_OPEN;
      else if (col_stb) cmd = CMD_COL;
      else              cmd = CMD_IDLE;
   end

endmodule

// File: rtl/mdram_cell_array.sv
module mdram_cell_array #(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int WIDTH       = 8,
   parameter int RA_W        = 2,
   parameter int CA_W        = 2,
   parameter bit RESET_CELLS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [RA_W-1:0]         rd_row,
   output logic [COLS*WIDTH-1:0]   rd_line,
   input  logic                    wr_en,
   input  logic [RA_W-1:0]         wr_row,
   input  logic [CA_W-1:0]         wr_col,
   input  logic [WIDTH-1:0]        wr_data
);

   logic [WIDTH-1:0] cells_w [ROWS][COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic             cell_we;
         logic [WIDTH-1:0] cell_q;

         assign cell_we = wr_en && (wr_row == RA_W'(r)) && (wr_col == CA_W'(c));

         if (RESET_CELLS) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       cell_q <= '0;
               else if (cell_we) cell_q <= wr_data;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (cell_we) cell_q <= wr_data;
            end
         end

         assign cells_w[r][c] = cell_q;
      end
   end

   // whole-row read port feeding the row buffer
   for (genvar c = 0; c < COLS; c++) begin : g_rd
      assign rd_line[c*WIDTH +: WIDTH] = cells_w[rd_row][c];
   end

endmodule

// File: rtl/mdram_row_buf.sv
module mdram_row_buf #(
   parameter int COLS  = 4,
   parameter int WIDTH = 8,
   parameter int CA_W  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [COLS*WIDTH-1:0] line_in,
   input  logic                  close,
   input  logic                  wr_en,
   input  logic [CA_W-1:0]       col,
   input  logic [WIDTH-1:0]      wr_data,
   output logic                  open_o,
   output logic [WIDTH-1:0]      cell_o
);

   logic [WIDTH-1:0] line_q [COLS];
   logic             open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < COLS; c++) line_q[c] <= '0;
      end else if (load) begin
         for (int c = 0; c < COLS; c++) line_q[c] <= line_in[c*WIDTH +: WIDTH];
      end else if (wr_en) begin
         line_q[col] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     open_q <= 1'b0;
      else if (close) open_q <= 1'b0;
      else if (load)  open_q <= 1'b1;
   end

   assign open_o = open_q;
   assign cell_o = line_q[col];

endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram
   import mdram_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int WIDTH       = 8,
   parameter bit RESET_CELLS = 1'b1,
   localparam int RA_W       = $clog2(ROWS),
   localparam int CA_W       = $clog2(COLS),
   localparam int ADDR_W     = (RA_W > CA_W) ? RA_W : CA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              close_row,
   input  logic              row_stb,
   input  logic              col_stb,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   output logic              rvalid,
   output logic              col_err
);

   if (ROWS < 2 || (1 << RA_W) != ROWS) begin : g_chk_rows
      $error("ROWS must be a power of two, at least 2");
   end
   if (COLS < 2 || (1 << CA_W) != COLS) begin : g_chk_cols
      $error("COLS must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("WIDTH must be positive");
   end

   localparam int LINE_W = COLS * WIDTH;

   mdram_cmd_e        cmd;
   logic [RA_W-1:0]   row_idx;
   logic [CA_W-1:0]   col_idx;
   logic [RA_W-1:0]   open_row_q;
   logic [LINE_W-1:0] arr_line;
   logic [WIDTH-1:0]  buf_cell;
   logic              row_open;
   logic              do_open, do_close, col_hit, col_miss, do_write, do_read;
   logic [WIDTH-1:0]  rdata_q;
   logic              rvalid_q, err_q;

   assign row_idx = addr[RA_W-1:0];
   assign col_idx = addr[CA_W-1:0];

   mdram_cmd_dec u_dec (
      .close_row (close_row),
      .row_stb   (row_stb),
      .col_stb   (col_stb),
      .cmd       (cmd)
   );

   assign do_open  = (cmd == CMD_OPEN);
   assign do_close = (cmd == CMD_CLOSE);
   assign col_hit  = (cmd == CMD_COL) && row_open;
   assign col_miss = (cmd == CMD_COL) && !row_open;
   assign do_write = col_hit && we;
   assign do_read  = col_hit && !we;

   mdram_cell_array #(
      .ROWS        (ROWS),
      .COLS        (COLS),
      .WIDTH       (WIDTH),
      .RA_W        (RA_W),
      .CA_W        (CA_W),
      .RESET_CELLS (RESET_CELLS)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_row  (row_idx),
      .rd_line (arr_line),
      .wr_en   (do_write),
      .wr_row  (open_row_q),
      .wr_col  (col_idx),
      .wr_data (wdata)
   );

   mdram_row_buf #(
      .COLS  (COLS),
      .WIDTH (WIDTH),
      .CA_W  (CA_W)
   ) u_rowbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (do_open),
      .line_in (arr_line),
      .close   (do_close),
      .wr_en   (do_write),
      .col     (col_idx),
      .wr_data (wdata),
      .open_o  (row_open),
      .cell_o  (buf_cell)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       open_row_q <= '0;
      else if (do_open) open_row_q <= row_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         rvalid_q <= do_read;
         err_q    <= col_miss;
         if (do_read)       rdata_q <= buf_cell;
         else if (col_miss) rdata_q <= '0;
      end
   end

   assign rdata   = rdata_q;
   assign rvalid  = rvalid_q;
   assign col_err = err_q;

endmodule

// File: rtl/mdram_chk.sv
module mdram_chk #(
   parameter int ADDR_W = 2,
   parameter int WIDTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              close_row,
   input logic              row_stb,
   input logic              col_stb,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [WIDTH-1:0]  wdata,
   input logic [WIDTH-1:0]  rdata,
   input logic              rvalid,
   input logic              col_err
);

   // open/closed state rebuilt from the strobes alone
   logic open_m;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         open_m <= 1'b0;
      else if (close_row) open_m <= 1'b0;
      else if (row_stb)   open_m <= 1'b1;
   end

   logic col_only;
   assign col_only = col_stb && !row_stb && !close_row;

   // R2: read on an open row yields valid data next cycle
   a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (col_only && !we && open_m) |=> (rvalid && !col_err));

   // R4: write on an open row raises neither flag
   a_r4_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (col_only && we && open_m) |=> (!rvalid && !col_err));

   // R5: column access with no open row errors out with zero data
   a_r5_err_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (col_only && !open_m) |=> (col_err && !rvalid && rdata == '0));

   // R7: a column strobe beaten by a higher-priority request does nothing
   a_r7_col_outranked: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_only) |=> (!rvalid && !col_err));

   // R8: flags never coincide
   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rvalid && col_err));

   // R8: data holds unless a read or an error updates it
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(col_only && (!we || !open_m)) |=> $stable(rdata));

   // R1: no flag right out of reset
   a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rvalid && !col_err));

   logic unused_ok;
   assign unused_ok = ^{addr, wdata};

endmodule

bind mux_addr_dram mdram_chk #(
   .ADDR_W (ADDR_W),
   .WIDTH  (WIDTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .close_row (close_row),
   .row_stb   (row_stb),
   .col_stb   (col_stb),
   .we        (we),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .rvalid    (rvalid),
   .col_err   (col_err)
);

// File: tb/mux_addr_dram_tb.sv
`timescale 1ns/1ps
module mux_addr_dram_tb;

   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int WIDTH = 8;
   localparam int AW    = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             close_row = 1'b0, row_stb = 1'b0, col_stb = 1'b0, we = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [WIDTH-1:0] wdata = '0;
   logic [WIDTH-1:0] rdata;
   logic             rvalid, col_err;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [WIDTH-1:0] model [ROWS][COLS];

   always #4 clk = ~clk;

   mux_addr_dram #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .close_row(close_row), .row_stb(row_stb),
      .col_stb(col_stb), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid), .col_err(col_err)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one strobe cycle; returns at the falling edge after the sampling edge
   task automatic cyc(bit p, bit r, bit c, bit w, logic [AW-1:0] a, logic [WIDTH-1:0] d);
      @(negedge clk);
      close_row = p; row_stb = r; col_stb = c; we = w; addr = a; wdata = d;
      @(negedge clk);
      close_row = 0; row_stb = 0; col_stb = 0; we = 0;
   endtask

   function automatic logic [WIDTH-1:0] pat(int r, int c);
      return 8'((r * 8'h21) + (c * 8'h0B) + 8'h17);
   endfunction

   task automatic read_expect(string req, int c, logic [WIDTH-1:0] exp);
      cyc(0, 0, 1, 0, AW'(c), '0);
      check({req, " rvalid"}, 32'(rvalid), 1);
      check({req, " col_err"}, 32'(col_err), 0);
      check({req, " rdata"}, 32'(rdata), 32'(exp));
   endtask

   task automatic read_err(string req, int c);
      cyc(0, 0, 1, 0, AW'(c), '0);
      check({req, " col_err"}, 32'(col_err), 1);
      check({req, " rvalid"}, 32'(rvalid), 0);
      check({req, " rdata zero"}, 32'(rdata), 0);
   endtask

   task automatic t_reset_state();
      check("R1 rdata", 32'(rdata), 0);
      check("R1 rvalid", 32'(rvalid), 0);
      check("R1 col_err", 32'(col_err), 0);
      read_err("R1 R5 no row open", 1);
      cyc(0, 1, 0, 0, 2'd3, '0);
      read_expect("R1 cell zero", 2, 8'h00);
      cyc(1, 0, 0, 0, '0, '0);
   endtask

   task automatic t_fill();
      for (int r = 0; r < ROWS; r++) begin
         cyc(0, 1, 0, 0, AW'(r), '0);
         for (int c = 0; c < COLS; c++) begin
            cyc(0, 0, 1, 1, AW'(c), pat(r, c));
            model[r][c] = pat(r, c);
            check("R4 write no rvalid", 32'(rvalid), 0);
            check("R4 write no col_err", 32'(col_err), 0);
         end
         cyc(1, 0, 0, 0, '0, '0);
      end
   endtask

   task automatic t_page_reads();
      logic [WIDTH-1:0] held;
      cyc(0, 1, 0, 0, 2'd2, '0);
      read_expect("R2 cell(2,1)", 1, model[2][1]);
      read_expect("R3 page hit (2,3)", 3, model[2][3]);
      read_expect("R3 page hit (2,0)", 0, model[2][0]);
      read_expect("R3 page hit (2,1) again", 1, model[2][1]);
      held = rdata;
      @(negedge clk);
      check("R8 rvalid pulse ends", 32'(rvalid), 0);
      check("R8 rdata held", 32'(rdata), 32'(held));
   endtask

   task automatic t_write_through();
      cyc(0, 1, 0, 0, 2'd1, '0);
      cyc(0, 0, 1, 1, 2'd2, 8'h5A);
      model[1][2] = 8'h5A;
      check("R8 rdata held over write", 32'(rdata), 32'(model[2][1]));
      read_expect("R4 buffer updated", 2, 8'h5A);
      cyc(1, 0, 0, 0, '0, '0);
      cyc(0, 1, 0, 0, 2'd1, '0);
      read_expect("R4 array updated", 2, 8'h5A);
      read_expect("R4 neighbour intact", 3, model[1][3]);
   endtask

   task automatic t_closed();
      cyc(1, 0, 0, 0, '0, '0);
      read_err("R6 closed row", 0);
      cyc(0, 0, 1, 1, 2'd3, 8'hFF);
      check("R5 closed write errs", 32'(col_err), 1);
      @(negedge clk);
      check("R8 col_err pulse ends", 32'(col_err), 0);
      cyc(0, 1, 0, 0, 2'd3, '0);
      read_expect("R5 closed write ignored", 3, model[3][3]);
   endtask

   task automatic t_priority();
      cyc(1, 0, 0, 0, '0, '0);
      cyc(0, 1, 1, 0, 2'd2, '0);
      check("R7 col under row: no rvalid", 32'(rvalid), 0);
      check("R7 col under row: no col_err", 32'(col_err), 0);
      read_expect("R7 row wins over col", 2, model[2][2]);
      cyc(1, 1, 0, 0, 2'd0, '0);
      read_err("R7 close wins over row", 0);
      cyc(0, 1, 0, 0, 2'd1, '0);
      cyc(1, 0, 1, 1, 2'd0, 8'h11);
      check("R7 close over write: no col_err", 32'(col_err), 0);
      cyc(0, 1, 0, 0, 2'd1, '0);
      read_expect("R7 write under close ignored", 0, model[1][0]);
   endtask

   task automatic t_row_switch();
      cyc(0, 1, 0, 0, 2'd0, '0);
      read_expect("R9 first row", 1, model[0][1]);
      cyc(0, 1, 0, 0, 2'd3, '0);
      read_expect("R9 buffer replaced", 1, model[3][1]);
      read_expect("R9 buffer replaced col2", 2, model[3][2]);
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) model[r][c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_fill();
      t_page_reads();
      t_write_through();
      t_closed();
      t_priority();
      t_row_switch();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

endmodule